// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block is the receive half of a synchronous serial port. Once a start strobe is accepted, it first spends a programmable number of bit periods in a sync phase. During that phase it drives a sync-active output and shifts the incoming bits into a sync-data register. After the sync phase it collects a programmable number of data words. Each word has a programmable length and bit order. Every completed word appears on a 32-bit output, together with a one-cycle valid strobe and a code that tells a downstream DMA engine which transfer width to use.

All logic runs on one system clock. The serial bit clock is treated as a sampled signal: a bit is taken on the first system clock edge that sees it high after it was low. A loop-back bit in the mode word replaces the receive-side data, frame-sync and bit-clock lines with their transmit-side counterparts. This allows a transmitter to be tested against this receiver without external wiring. The mode word is captured when a frame starts, so software may rewrite it during a frame without disturbing the frame in progress. The loop-back bit is the exception and acts immediately.

Top module: `serial_frame_rx`

## Requirements
- R1: Mode word fields are: bits 4:0 word length code L, bit 5 loop-back, bit 7 MSB-first, bits 11:8 words-per-frame code W, bits 19:16 sync length code S. No other bit of the mode word changes any output.
- R2: Each data word holds L+1 bits, taken on successive rising edges of the selected bit clock.
- R3: With every valid word, `xfer_size_o` is 0 (byte) when L is 7 or less, 1 (half-word) when L is 8 to 15, and 2 (32-bit word) when L is 16 or more. Code 3 never appears.
- R4: With MSB-first set, the first received bit of a word lands in bit L and the last in bit 0. With it clear, the first bit lands in bit 0 and the last in bit L.
- R5: Bits of `word_o` above bit L read as zero when a word is presented.
- R6: After a start, exactly W+1 words are delivered. Later bit-clock edges produce no word until the next accepted start.
- R7: `sync_active_o` rises on the system clock edge that accepts a start. It stays high through S+1 bit-clock rising edges and is low on the edge that takes the (S+1)th. No word is valid while it is high.
- R8: At the end of the sync phase, `sync_data_o` holds the S+1 sync-phase bits. The earliest bit is at bit S, the latest at bit 0, and the upper bits are zero.
- R9: With loop-back set, data, frame sync and bit clock come from `tx_data_i`, `tx_fs_i` and `tx_clk_i`, and the receive-side pins are ignored. `fs_mon_o` shows the selected frame-sync line.
- R10: `word_valid_o` is high for exactly one system cycle, starting at the system clock edge that detects the bit-clock rise carrying the word's last bit.
- R11: While L is 0, `cfg_err_o` is high and a start strobe is ignored. The receiver stays idle, with no sync phase and no words.
- R12: A low `rst_n` at a system clock edge returns the receiver to idle and clears the valid strobe, the sync-active flag, the sync-data register and the word output.
- R13: Every field except loop-back is captured when a start is accepted. Changes to the mode word during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 32 | Mode word |
| start_i | input | 1 | Start strobe, accepted while idle |
| rx_clk_i | input | 1 | Receive bit clock |
| rx_data_i | input | 1 | Receive serial data |
| rx_fs_i | input | 1 | Receive frame-sync line |
| tx_clk_i | input | 1 | Transmit bit clock (loop-back source) |
| tx_data_i | input | 1 | Transmit serial data (loop-back source) |
| tx_fs_i | input | 1 | Transmit frame sync (loop-back source) |
| word_o | output | 32 | Last completed word |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| xfer_size_o | output | 2 | Transfer width code for the word |
| sync_data_o | output | 16 | Bits sampled during the sync phase |
| sync_active_o | output | 1 | High during the sync phase |
| fs_mon_o | output | 1 | Selected frame-sync line |
| cfg_err_o | output | 1 | Word length code is zero |

## Verification
Bit capture has two registers on its path: the bit-clock edge detector, and the word and state registers. A word, its size code and the state change are therefore all visible just after the system edge on which a raised bit clock is first seen. The bench raises the line half a cycle before that edge and reads the outputs one time unit after it. It waits one further edge to confirm that the strobe has dropped. `sync_active_o` is read one unit after the edge that samples the start strobe, and again after each sync bit's edge. `fs_mon_o` and `cfg_err_o` are combinational and are read a unit after their inputs change.

// File: rtl/sfrx_pkg.sv
// Package: shared field positions, widths, state and size encodings for the
// framed serial receiver. Assumes a 32-bit mode word and a 32-bit data word.
package sfrx_pkg;

    localparam int DLEN_W      = 5;
    localparam int WCNT_W      = 4;
    localparam int SLEN_W      = 4;
    localparam int F_DLEN_LSB  = 0;
    localparam int F_LOOP      = 5;
    localparam int F_MSBF      = 7;
    localparam int F_WCNT_LSB  = 8;
    localparam int F_SLEN_LSB  = 16;

    typedef enum logic [1:0] {
        XF_BYTE = 2'd0,
        XF_HALF = 2'd1,
        XF_WORD = 2'd2
    } xfer_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [DLEN_W-1:0] dlen;
        logic              msbf;
        logic [WCNT_W-1:0] words;
        logic [SLEN_W-1:0] slen;
    } rx_cfg_t;

    // Maps a word length code to the DMA transfer width.
    function automatic xfer_e size_of(input logic [DLEN_W-1:0] d);
        if (d <= DLEN_W'(7))       return XF_BYTE;
        else if (d <= DLEN_W'(15)) return XF_HALF;
        else                       return XF_WORD;
    endfunction

endpackage

// File: rtl/sfrx_line_sel.sv
// Line selector: picks receive or transmit lines (loop-back) and turns the
// selected bit clock into a one-system-cycle strobe on its rising edge.
// Assumes the bit clock is slower than half the system clock.
module sfrx_line_sel #(
    parameter int N_LINES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loop_en,
    input  logic [N_LINES-1:0] rx_lines,   // {fs, data, clock}
    input  logic [N_LINES-1:0] tx_lines,   // {fs, data, clock}
    output logic               bit_stb,
    output logic               bit_val,
    output logic               fs_sel
);

    logic [N_LINES-1:0] sel_lines;
    logic               ck_q;

    // Per-line loop-back multiplexer.
    for (genvar g = 0; g < N_LINES; g++) begin : g_mux
        assign sel_lines[g] = loop_en ? tx_lines[g] : rx_lines[g];
    end

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= 1'b0;
        else        ck_q <= sel_lines[0];
    end

    assign bit_stb = sel_lines[0] & ~ck_q;
    assign bit_val = sel_lines[1];
    assign fs_sel  = sel_lines[2];

endmodule

// File: rtl/sfrx_frame_ctrl.sv
// Frame controller: accepts a start while idle, captures the configuration,
// runs the sync phase (filling the sync register), then counts bits and
// words of the data phase. Assumes dlen is never 0 once a frame runs.
module sfrx_frame_ctrl
    import sfrx_pkg::*;
#(
    parameter int SYNC_W = 2**SLEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  rx_cfg_t             cfg_in,
    input  logic                cfg_bad,
    input  logic                bit_stb,
    input  logic                bit_val,
    output rx_cfg_t             cfg_q,
    output logic                shift_en,
    output logic                first_bit,
    output logic                last_bit,
    output logic [DLEN_W-1:0]   bit_idx,
    output logic                sync_act,
    output logic [SYNC_W-1:0]   sync_data,
    output logic                idle
);

    rx_state_e          st;
    logic [SLEN_W-1:0]  scnt;
    logic [DLEN_W-1:0]  bcnt;
    logic [WCNT_W-1:0]  wcnt;

    // Frame sequencing, counters and sync-phase sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cfg_q     <= '0;
            scnt      <= '0;
            bcnt      <= '0;
            wcnt      <= '0;
            sync_data <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i && !cfg_bad) begin
                        st        <= ST_SYNC;
                        cfg_q     <= cfg_in;
                        scnt      <= '0;
                        bcnt      <= '0;
                        wcnt      <= '0;
                        sync_data <= '0;
                    end
                end
                ST_SYNC: begin
                    if (bit_stb) begin
                        sync_data <= {sync_data[SYNC_W-2:0], bit_val};
                        if (scnt == cfg_q.slen) st <= ST_DATA;
                        else                    scnt <= scnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_stb) begin
                        if (bcnt == cfg_q.dlen) begin
                            bcnt <= '0;
                            if (wcnt == cfg_q.words) st <= ST_IDLE;
                            else                     wcnt <= wcnt + 1'b1;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the word assembler and status outputs.
    always_comb begin
        shift_en  = (st == ST_DATA) && bit_stb;
        first_bit = (bcnt == '0);
        last_bit  = (bcnt == cfg_q.dlen);
        bit_idx   = bcnt;
        sync_act  = (st == ST_SYNC);
        idle      = (st == ST_IDLE);
    end

endmodule

// File: rtl/sfrx_word_asm.sv
// Word assembler: places each data bit by bit order, presents the finished
// word with a one-cycle valid strobe and its transfer width code.
// Assumes DATA_W equals 2**DLEN_W.
module sfrx_word_asm
    import sfrx_pkg::*;
#(
    parameter int DATA_W = 2**DLEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              first_bit,
    input  logic              last_bit,
    input  logic [DLEN_W-1:0] bit_idx,
    input  logic              bit_val,
    input  logic              msbf,
    input  logic [DLEN_W-1:0] dlen,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o,
    output logic [1:0]        size_o
);

    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_base;
    logic [DATA_W-1:0] acc_nxt;

    // Next accumulator value: shift in at bit 0 or write at the bit index.
    always_comb begin
        acc_base = first_bit ? '0 : acc;
        if (msbf) begin
            acc_nxt = {acc_base[DATA_W-2:0], bit_val};
        end else begin
            acc_nxt          = acc_base;
            acc_nxt[bit_idx] = bit_val;
        end
    end

    // Accumulate bits and publish a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
            size_o  <= 2'b00;
        end else begin
            valid_o <= shift_en && last_bit;
            if (shift_en) acc <= acc_nxt;
            if (shift_en && last_bit) begin
                word_o <= acc_nxt;
                size_o <= size_of(dlen);
            end
        end
    end

endmodule

// File: rtl/serial_frame_rx.sv
// Top: framed serial word receiver. Decodes the mode word, selects lines,
// sequences frames and assembles words. Assumes one system clock and a
// sampled (slower) serial bit clock; reset is synchronous and active low.
module serial_frame_rx
    import sfrx_pkg::*;
#(
    parameter int MODE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                start_i,
    input  logic                rx_clk_i,
    input  logic                rx_data_i,
    input  logic                rx_fs_i,
    input  logic                tx_clk_i,
    input  logic                tx_data_i,
    input  logic                tx_fs_i,
    output logic [31:0]         word_o,
    output logic                word_valid_o,
    output logic [1:0]          xfer_size_o,
    output logic [15:0]         sync_data_o,
    output logic                sync_active_o,
    output logic                fs_mon_o,
    output logic                cfg_err_o
);

    localparam int DATA_W = 2**DLEN_W;
    localparam int SYNC_W = 2**SLEN_W;

    rx_cfg_t            cfg_in;
    rx_cfg_t            cfg_q;
    logic               loop_en;
    logic               bit_stb;
    logic               bit_val;
    logic               shift_en;
    logic               first_bit;
    logic               last_bit;
    logic [DLEN_W-1:0]  bit_idx;
    logic               idle_w;
    logic               unused_mode_bits;

    // Field decode of the live mode word.
    always_comb begin
        cfg_in.dlen  = mode_i[F_DLEN_LSB +: DLEN_W];
        cfg_in.msbf  = mode_i[F_MSBF];
        cfg_in.words = mode_i[F_WCNT_LSB +: WCNT_W];
        cfg_in.slen  = mode_i[F_SLEN_LSB +: SLEN_W];
        loop_en      = mode_i[F_LOOP];
        cfg_err_o    = (cfg_in.dlen == '0);
    end

    assign unused_mode_bits = ^{mode_i[MODE_W-1:20], mode_i[15:12], mode_i[6]};

    sfrx_line_sel #(.N_LINES(3)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_en  (loop_en),
        .rx_lines ({rx_fs_i, rx_data_i, rx_clk_i}),
        .tx_lines ({tx_fs_i, tx_data_i, tx_clk_i}),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .fs_sel   (fs_mon_o)
    );

    sfrx_frame_ctrl #(.SYNC_W(SYNC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cfg_in    (cfg_in),
        .cfg_bad   (cfg_err_o),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .cfg_q     (cfg_q),
        .shift_en  (shift_en),
        .first_bit (first_bit),
        .last_bit  (last_bit),
        .bit_idx   (bit_idx),
        .sync_act  (sync_active_o),
        .sync_data (sync_data_o),
        .idle      (idle_w)
    );

    sfrx_word_asm #(.DATA_W(DATA_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .first_bit (first_bit),
        .last_bit  (last_bit),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .msbf      (cfg_q.msbf),
        .dlen      (cfg_q.dlen),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .size_o    (xfer_size_o)
    );

endmodule

// File: rtl/sfrx_checker.sv
// Checker: temporal properties of the framed serial receiver, bound to the
// top. Assumes the port and internal names of serial_frame_rx.
module sfrx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [1:0]  xfer_size,
    input logic [31:0] word,
    input logic [15:0] sync_data,
    input logic        sync_active,
    input logic        cfg_err,
    input logic        idle
);

    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> xfer_size != 2'b11);

    a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && xfer_size == 2'b00) |-> word[31:8] == '0);

    a_r5_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && xfer_size == 2'b01) |-> word[31:16] == '0);

    a_r7_sync_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |-> !word_valid);

    a_r11_bad_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cfg_err) |=> (idle && !sync_active));

    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && !sync_active && idle && sync_data == '0 && word == '0));

endmodule

bind serial_frame_rx sfrx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid_o),
    .xfer_size   (xfer_size_o),
    .word        (word_o),
    .sync_data   (sync_data_o),
    .sync_active (sync_active_o),
    .cfg_err     (cfg_err_o),
    .idle        (idle_w)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mode_i = 32'h0000_0007;
    logic        start_i = 1'b0;
    logic        rx_clk_i = 1'b0, rx_data_i = 1'b0, rx_fs_i = 1'b0;
    logic        tx_clk_i = 1'b0, tx_data_i = 1'b0, tx_fs_i = 1'b0;
    logic [31:0] word_o;
    logic        word_valid_o;
    logic [1:0]  xfer_size_o;
    logic [15:0] sync_data_o;
    logic        sync_active_o;
    logic        fs_mon_o;
    logic        cfg_err_o;

    int total = 0;
    int bad   = 0;
    bit loop_mode = 1'b0;

    logic        cap_valid;
    logic [31:0] cap_word;
    logic [1:0]  cap_size;
    logic        cap_sync;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
        .rx_clk_i(rx_clk_i), .rx_data_i(rx_data_i), .rx_fs_i(rx_fs_i),
        .tx_clk_i(tx_clk_i), .tx_data_i(tx_data_i), .tx_fs_i(tx_fs_i),
        .word_o(word_o), .word_valid_o(word_valid_o), .xfer_size_o(xfer_size_o),
        .sync_data_o(sync_data_o), .sync_active_o(sync_active_o),
        .fs_mon_o(fs_mon_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_bits(input logic [31:0] seq, input int n, input bit msbf);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) begin
            if (msbf) v = {v[30:0], seq[i]};
            else      v[i] = seq[i];
        end
        return v;
    endfunction

    function automatic logic [1:0] exp_size(input int dlen);
        if (dlen <= 7)  return 2'd0;
        if (dlen <= 15) return 2'd1;
        return 2'd2;
    endfunction

    // Drive the chosen side; the other side carries inverted noise.
    task automatic drive_line(input logic ck, input logic d);
        if (loop_mode) begin
            tx_clk_i = ck; tx_data_i = d; rx_clk_i = ~ck; rx_data_i = ~d;
        end else begin
            rx_clk_i = ck; rx_data_i = d; tx_clk_i = ~ck; tx_data_i = ~d;
        end
    endtask

    // One bit period; outputs captured just after the sampling edge.
    task automatic send_bit(input logic b);
        @(negedge clk) drive_line(1'b0, b);
        @(negedge clk) drive_line(1'b1, b);
        @(posedge clk);
        #1;
        cap_valid = word_valid_o;
        cap_word  = word_o;
        cap_size  = xfer_size_o;
        cap_sync  = sync_active_o;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] mode, input bit mid_change);
        int dlen  = int'(mode[4:0]);
        bit msbf  = mode[7];
        int words = int'(mode[11:8]);
        int slen  = int'(mode[19:16]);
        logic [31:0] seq;
        loop_mode = mode[5];
        mode_i = mode;
        pulse_start();
        chk(sync_active_o == 1'b1, "R7", "sync high after start", 32'(sync_active_o), 1);
        if (mid_change) mode_i = ($urandom & ~32'h20) | (mode & 32'h20); // R13
        seq = $urandom;
        for (int i = 0; i <= slen; i++) begin
            send_bit(seq[i]);
            if (i < slen) chk(cap_sync == 1'b1 && !cap_valid, "R7", "sync held", 32'(cap_sync), 1);
        end
        chk(cap_sync == 1'b0, "R7", "sync ends after S+1 bits", 32'(cap_sync), 0);
        chk(sync_data_o == 16'(pack_bits(seq, slen + 1, 1'b1)), "R8", "sync data",
            32'(sync_data_o), pack_bits(seq, slen + 1, 1'b1));
        for (int w = 0; w <= words; w++) begin
            seq = $urandom;
            for (int i = 0; i <= dlen; i++) begin
                send_bit(seq[i]);
                if (i < dlen) chk(!cap_valid, "R2", "no word before last bit", 32'(cap_valid), 0);
            end
            chk(cap_valid, "R10", "valid with last bit", 32'(cap_valid), 1);
            chk(cap_word == pack_bits(seq, dlen + 1, msbf), msbf ? "R4 msb-first" : "R4 lsb-first",
                mid_change ? "R13 word after mode change" : "word value",
                cap_word, pack_bits(seq, dlen + 1, msbf));
            if (dlen < 31) chk((cap_word >> (dlen + 1)) == 0, "R5", "upper bits zero", cap_word, 0);
            chk(cap_size == exp_size(dlen), "R3", "size code", 32'(cap_size), 32'(exp_size(dlen)));
            @(posedge clk); #1;
            chk(!word_valid_o, "R10", "valid one cycle", 32'(word_valid_o), 0);
        end
        for (int k = 0; k < 3; k++) begin
            send_bit(1'($urandom));
            chk(!cap_valid && !cap_sync, "R6", "no word after frame", 32'(cap_valid), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(!word_valid_o && !sync_active_o && sync_data_o == 0 && word_o == 0,
            "R12", "reset state", {word_valid_o, sync_active_o, 14'(0), sync_data_o}, 0);
        @(negedge clk) rst_n = 1'b1;

        // Directed boundaries of the length code and bit order.
        run_frame(32'h0000_0087, 0);            // L=7 byte, msb-first
        run_frame(32'h0000_0008, 0);            // L=8 half, lsb-first
        run_frame(32'h0001_008F, 0);            // L=15
        run_frame(32'h000F_0110, 0);            // L=16, S=15, 2 words
        run_frame(32'h0003_009F, 0);            // L=31
        run_frame(32'h0000_0001, 0);            // L=1
        run_frame(32'hFFF0_F047 | 32'h0000_0000, 0); // R1 reserved bits set, L=7
        run_frame(32'h0002_00A5, 0);            // R9 loop-back, msb-first

        // R11: illegal length code.
        mode_i = 32'h0000_0080; loop_mode = 0;
        #1 chk(cfg_err_o == 1'b1, "R11", "cfg error flag", 32'(cfg_err_o), 1);
        pulse_start();
        chk(!sync_active_o, "R11", "start ignored", 32'(sync_active_o), 0);
        for (int k = 0; k < 6; k++) begin
            send_bit(1'b1);
            chk(!cap_valid && !cap_sync, "R11", "stays idle", 32'(cap_valid), 0);
        end
        mode_i = 32'h0000_0003;
        #1 chk(cfg_err_o == 1'b0, "R11", "flag clears", 32'(cfg_err_o), 0);

        // R9: frame-sync selection.
        rx_fs_i = 1; tx_fs_i = 0; mode_i = 32'h0000_0003;
        #1 chk(fs_mon_o == 1'b1, "R9", "fs from rx side", 32'(fs_mon_o), 1);
        mode_i = 32'h0000_0023;
        #1 chk(fs_mon_o == 1'b0, "R9", "fs from tx side", 32'(fs_mon_o), 0);
        tx_fs_i = 1; rx_fs_i = 0;
        #1 chk(fs_mon_o == 1'b1, "R9", "fs follows tx", 32'(fs_mon_o), 1);

        // R12: reset in the middle of a sync phase.
        mode_i = 32'h0007_0007; loop_mode = 0;
        pulse_start();
        send_bit(1'b1); send_bit(1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk(!sync_active_o && sync_data_o == 0, "R12", "mid-frame reset",
            {15'(0), sync_active_o, sync_data_o}, 0);
        @(negedge clk) rst_n = 1'b1;

        // Random frames, some with mode rewrites mid-frame (R13) and garbage reserved bits (R1).
        for (int f = 0; f < 40; f++) begin
            logic [31:0] m = $urandom;
            m[4:0] = 5'd1 + 5'($urandom_range(0, 30));
            m[11:8] = 4'($urandom_range(0, 3));
            run_frame(m, f[0]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule